// File: doc/BRIEF.md
# Front-End Fast Command Decoder

This block sits on a front-end board and takes one 24-bit fast-control word per bunch-clock cycle, qualified by a valid strobe. It keeps a local bunch counter and event counter. From the command flags it derives the per-crossing strobes that the readout logic needs: full readout, header only, non-zero-suppressed (all-channel) readout and a calibration pulse. It also compares the bunch ID in each word with its own bunch count and latches a flag if the two ever disagree.

The flags are applied in a fixed order. Counter resets come first, then the veto (an explicit one, or one forced by a recent all-channel readout), then header-only, and last the readout and all-channel requests. A crossing that is vetoed is not counted as an event and only a header is emitted for it. After an all-channel readout, a programmable number of following crossings are treated as vetoed so that the larger payload can be packed.

Top module: `fast_cmd_decoder`

## Requirements
- R1: Word layout: bits 11..0 hold the bunch ID. Bit 12 is readout, bit 13 veto, bit 14 header-only, bit 15 all-channel readout, bit 16 calibration, bit 17 bunch-count reset, bit 18 front-end reset and bit 19 event-count reset. Bits 23..20 have no effect on any output.
- R2: The bunch counter advances by one on every clock edge, valid or not, and wraps from BX_LAST to 0.
- R3: A valid word with bit 17 or bit 18 set marks that crossing as bunch 0, so the counter reads 1 after that edge. No bunch-ID comparison is made for that word.
- R4: The event counter rises by one for each valid crossing that is not vetoed. A valid word with bit 18 or bit 19 set sets it to 0, and that crossing is not counted.
- R5: A valid word with bit 13 set gives header_only=1, readout=0 and full_readout=0, and is not counted.
- R6: A valid, non-vetoed word with bit 14 set gives header_only=1, readout=0 and full_readout=0, and is counted.
- R7: Strobes are registered and appear one cycle after the word. readout=1 only for a valid word with bit 12 set that is neither vetoed nor header-only. When cmd_valid is low, all strobes are 0 and the event counter holds.
- R8: A valid word with bit 15 set that is neither vetoed nor header-only gives full_readout=1 one cycle later. The next NZS_HOLD valid words are then handled as vetoed (R5), including any bit 15 they carry.
- R9: A valid word with bit 16 set gives a one-cycle cal_pulse exactly CAL_LAT cycles after the word, whether or not the crossing is vetoed.
- R10: A valid word without bit 17 or 18 whose bunch ID differs from the local count sets bx_mismatch one cycle later. The flag stays set until rst_n is asserted.
- R11: While and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | cmd_word carries a command this cycle |
| cmd_word | input | 24 | Fast-control word |
| bx_cnt | output | 12 | Local bunch count expected for the next word |
| evt_cnt | output | EVT_W | Event count |
| readout | output | 1 | Read out this crossing |
| header_only | output | 1 | Emit only a header for this crossing |
| full_readout | output | 1 | Read out all channels for this crossing |
| cal_pulse | output | 1 | Delayed calibration pulse |
| bx_mismatch | output | 1 | Sticky bunch-ID disagreement flag |

## Verification
Several rules are checked on every cycle: the bunch counter steps or resynchronises correctly, a clear flag empties the event counter, a veto suppresses readout, the mismatch flag never drops, and an all-channel readout is never followed directly by another. The bench scenarios are needed for the rest: the exact event counts across a mix of vetoed and header-only crossings, the length of the forced veto window, the calibration delay, the wrap at the end of the orbit, and the fact that the reserved bits have no effect.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int WORD_W = 24;
    localparam int BID_W  = 12;
    localparam int FLAG_LSB = 12;
    localparam int FLAG_W   = 8;

    // bit 7 .. bit 0 map onto word bits 19 .. 12
    typedef struct packed {
        logic evrst;
        logic ferst;
        logic bxrst;
        logic cal;
        logic nzs;
        logic hdr;
        logic veto;
        logic read;
    } cmd_flags_t;

    typedef struct packed {
        logic readout;
        logic header;
        logic full;
    } strobe_t;

    function automatic cmd_flags_t get_flags(input logic [FLAG_W-1:0] raw);
        return cmd_flags_t'(raw);
    endfunction

endpackage

// File: rtl/fcd_bx_track.sv
module fcd_bx_track #(
    parameter int BX_W    = 12,
    parameter int BX_LAST = 3563
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic            sync_clr,
    input  logic [BX_W-1:0] rx_id,
    output logic [BX_W-1:0] bx_cnt,
    output logic            mismatch
);
    localparam logic [BX_W-1:0] LAST_V = BX_W'(BX_LAST);
    localparam logic [BX_W-1:0] ONE_V  = BX_W'(1);

    typedef struct packed {
        logic [BX_W-1:0] cnt;
        logic            mis;
    } bx_state_t;

    bx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid && !sync_clr && (rx_id != st_q.cnt)) begin
            st_d.mis = 1'b1;
        end
        if (valid && sync_clr) begin
            st_d.cnt = ONE_V;
        end else if (st_q.cnt == LAST_V) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + ONE_V;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bx_cnt   = st_q.cnt;
    assign mismatch = st_q.mis;

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int EVT_W    = 24,
    parameter int NZS_HOLD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  cmd_flags_t       flags,
    output strobe_t          strobes,
    output logic [EVT_W-1:0] evt_cnt
);
    localparam int HOLD_W = (NZS_HOLD > 0) ? $clog2(NZS_HOLD + 1) : 1;
    localparam logic [HOLD_W-1:0] HOLD_V = HOLD_W'(NZS_HOLD);

    typedef struct packed {
        strobe_t           stb;
        logic [EVT_W-1:0]  evt;
        logic [HOLD_W-1:0] hold;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic vetoed;
    logic hdr_only;

    always_comb begin
        st_d     = st_q;
        // sequence: counter clears, veto, header-only, readout requests
        vetoed   = valid && (flags.veto || (st_q.hold != '0));
        hdr_only = valid && (vetoed || flags.hdr);

        st_d.stb.header  = hdr_only;
        st_d.stb.readout = valid && flags.read && !hdr_only;
        st_d.stb.full    = valid && flags.nzs && !hdr_only;

        if (valid && (flags.ferst || flags.evrst)) begin
            st_d.evt = '0;
        end else if (valid && !vetoed) begin
            st_d.evt = st_q.evt + EVT_W'(1);
        end

        if (st_d.stb.full) begin
            st_d.hold = HOLD_V;
        end else if (valid && (st_q.hold != '0)) begin
            st_d.hold = st_q.hold - HOLD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobes = st_q.stb;
    assign evt_cnt = st_q.evt;

endmodule

// File: rtl/fcd_cal_delay.sv
module fcd_cal_delay #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    logic [LAT-1:0] pipe_d, pipe_q;

    generate
        if (LAT == 1) begin : g_single
            always_comb pipe_d = fire;
        end else begin : g_shift
            always_comb pipe_d = {pipe_q[LAT-2:0], fire};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign pulse = pipe_q[LAT-1];

endmodule

// File: rtl/fast_cmd_decoder.sv
module fast_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int BX_LAST  = 3563,
    parameter int EVT_W    = 24,
    parameter int NZS_HOLD = 3,
    parameter int CAL_LAT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output logic [BID_W-1:0]  bx_cnt,
    output logic [EVT_W-1:0]  evt_cnt,
    output logic              readout,
    output logic              header_only,
    output logic              full_readout,
    output logic              cal_pulse,
    output logic              bx_mismatch
);
    cmd_flags_t flags;
    strobe_t    stb;
    logic       unused_rsv;

    assign flags      = get_flags(cmd_word[FLAG_LSB +: FLAG_W]);
    assign unused_rsv = ^cmd_word[WORD_W-1:FLAG_LSB+FLAG_W];

    fcd_bx_track #(
        .BX_W    (BID_W),
        .BX_LAST (BX_LAST)
    ) u_bx (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (cmd_valid),
        .sync_clr (flags.bxrst | flags.ferst),
        .rx_id    (cmd_word[BID_W-1:0]),
        .bx_cnt   (bx_cnt),
        .mismatch (bx_mismatch)
    );

    fcd_seq #(
        .EVT_W    (EVT_W),
        .NZS_HOLD (NZS_HOLD)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (cmd_valid),
        .flags   (flags),
        .strobes (stb),
        .evt_cnt (evt_cnt)
    );

    fcd_cal_delay #(
        .LAT (CAL_LAT)
    ) u_cal (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (cmd_valid & flags.cal),
        .pulse (cal_pulse)
    );

    assign readout      = stb.readout;
    assign header_only  = stb.header;
    assign full_readout = stb.full;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import fcd_pkg::*;
#(
    parameter int BX_LAST  = 3563,
    parameter int EVT_W    = 24,
    parameter int NZS_HOLD = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input cmd_flags_t       flags,
    input logic [BID_W-1:0] bx_cnt,
    input logic [EVT_W-1:0] evt_cnt,
    input logic             readout,
    input logic             header_only,
    input logic             full_readout,
    input logic             cal_pulse,
    input logic             bx_mismatch
);
    localparam logic [BID_W-1:0] LAST_V = BID_W'(BX_LAST);
    logic unused_chk;
    assign unused_chk = ^{flags.read, flags.cal, flags.nzs, cal_pulse};

    a_r2_bx_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && (flags.bxrst || flags.ferst)) |=>
        (bx_cnt == (($past(bx_cnt) == LAST_V) ? '0 : $past(bx_cnt) + BID_W'(1))));

    a_r3_bx_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (flags.bxrst || flags.ferst)) |=> (bx_cnt == BID_W'(1)));

    a_r4_evt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (flags.ferst || flags.evrst)) |=> (evt_cnt == '0));

    a_r5_veto: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && flags.veto) |=> (header_only && !readout && !full_readout));

    a_r6_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && flags.hdr) |=> (header_only && !readout));

    a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
        readout |-> !header_only);

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bx_mismatch |=> bx_mismatch);

    generate
        if (NZS_HOLD > 0) begin : g_nzs
            a_r8_nzs_follow: assert property (@(posedge clk) disable iff (!rst_n)
                full_readout |=> !full_readout);
        end
    endgenerate

endmodule

bind fast_cmd_decoder fcd_checker #(
    .BX_LAST  (BX_LAST),
    .EVT_W    (EVT_W),
    .NZS_HOLD (NZS_HOLD)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .flags        (flags),
    .bx_cnt       (bx_cnt),
    .evt_cnt      (evt_cnt),
    .readout      (readout),
    .header_only  (header_only),
    .full_readout (full_readout),
    .cal_pulse    (cal_pulse),
    .bx_mismatch  (bx_mismatch)
);

// File: tb/tb_fast_cmd_decoder.sv
module tb_fast_cmd_decoder;
    localparam int CLK_P    = 10;
    localparam int BX_LAST  = 3563;
    localparam int EVT_W    = 24;
    localparam int NZS_HOLD = 3;
    localparam int CAL_LAT  = 4;

    localparam int F_READ = 12, F_VETO = 13, F_HDR = 14, F_NZS = 15;
    localparam int F_CAL = 16, F_BXR = 17, F_FER = 18, F_EVR = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [23:0] cmd_word = '0;
    logic [11:0] bx_cnt;
    logic [EVT_W-1:0] evt_cnt;
    logic readout, header_only, full_readout, cal_pulse, bx_mismatch;

    always #(CLK_P/2) clk = ~clk;

    fast_cmd_decoder #(
        .BX_LAST(BX_LAST), .EVT_W(EVT_W), .NZS_HOLD(NZS_HOLD), .CAL_LAT(CAL_LAT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .bx_cnt(bx_cnt), .evt_cnt(evt_cnt), .readout(readout),
        .header_only(header_only), .full_readout(full_readout),
        .cal_pulse(cal_pulse), .bx_mismatch(bx_mismatch)
    );

    typedef struct {
        bit    rd, ho, full, cal, mis;
        int    evt, bx;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    bit   cal_q[$];
    int   total = 0;
    int   bad = 0;

    // reference model state
    int m_bx, m_evt, m_hold;
    bit m_mis;

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_bx = 0; m_evt = 0; m_hold = 0; m_mis = 0;
        exp_q.delete();
        cal_q.delete();
        for (int i = 0; i < CAL_LAT - 1; i++) cal_q.push_back(1'b0);
    endtask

    function automatic logic [23:0] mk(int id, int fl);
        return {4'h0, 20'(fl), 12'(id)};
    endfunction

    // driver: called at negedge+1, applies a word, predicts, waits one cycle
    task automatic drive(bit v, logic [23:0] w, string tag);
        exp_t e;
        bit rstf, vet, ho;
        cmd_valid = v;
        cmd_word  = w;
        rstf = v && (w[F_BXR] || w[F_FER]);
        if (v && !rstf && (int'(w[11:0]) != m_bx)) m_mis = 1;
        vet  = v && (w[F_VETO] || m_hold > 0);
        ho   = v && (vet || w[F_HDR]);
        e.rd   = v && w[F_READ] && !ho;
        e.full = v && w[F_NZS] && !ho;
        e.ho   = ho;
        if (v && (w[F_FER] || w[F_EVR])) m_evt = 0;
        else if (v && !vet) m_evt++;
        if (e.full) m_hold = NZS_HOLD;
        else if (v && m_hold > 0) m_hold--;
        if (rstf) m_bx = 1;
        else m_bx = (m_bx == BX_LAST) ? 0 : m_bx + 1;
        cal_q.push_back(v && w[F_CAL]);
        e.cal = cal_q.pop_front();
        e.evt = m_evt; e.bx = m_bx; e.mis = m_mis; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk); #1;
    endtask

    task automatic send(int fl, string tag);
        drive(1'b1, mk(m_bx, fl), tag);
    endtask

    // monitor: compares outputs one cycle after each driven word
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, "readout R7",      int'(readout),      int'(e.rd));
            chk(e.tag, "header_only R5",  int'(header_only),  int'(e.ho));
            chk(e.tag, "full_readout R8", int'(full_readout), int'(e.full));
            chk(e.tag, "cal_pulse R9",    int'(cal_pulse),    int'(e.cal));
            chk(e.tag, "mismatch R10",    int'(bx_mismatch),  int'(e.mis));
            chk(e.tag, "evt_cnt R4",      int'(evt_cnt),      e.evt);
            chk(e.tag, "bx_cnt R2",       int'(bx_cnt),       e.bx);
        end
    end

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        cmd_word = '0;
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        // R11: reset state
        chk("R11", "outputs", int'({readout, header_only, full_readout, cal_pulse, bx_mismatch}), 0);
        chk("R11", "counters", int'(evt_cnt) + int'(bx_cnt), 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // R7 basic readout and plain crossings
        send(1 << F_READ, "R7");
        send(0, "R7");
        send(1 << F_READ, "R7");
        drive(1'b0, mk(0, (1 << F_READ) | (1 << F_NZS) | (1 << F_CAL)), "R7 invalid");
        drive(1'b0, mk(0, 1 << F_EVR), "R7 invalid");

        // R5 veto, R6 header only
        send((1 << F_VETO) | (1 << F_READ), "R5");
        send((1 << F_VETO) | (1 << F_NZS), "R5");
        send((1 << F_HDR) | (1 << F_READ), "R6");
        send(1 << F_HDR, "R6");
        send(1 << F_READ, "R7");

        // R8 all-channel readout then forced veto window
        send((1 << F_NZS) | (1 << F_READ), "R8");
        send((1 << F_NZS) | (1 << F_READ), "R8");
        send(1 << F_READ, "R8");
        drive(1'b0, '0, "R8 gap");
        send(1 << F_NZS, "R8");
        send(1 << F_READ, "R8");
        send(1 << F_READ, "R8");

        // R9 calibration, including on a vetoed crossing
        send(1 << F_CAL, "R9");
        send(0, "R9");
        send((1 << F_CAL) | (1 << F_VETO), "R9");
        for (int i = 0; i < 6; i++) send(1 << F_READ, "R9");

        // R1 reserved bits have no effect
        drive(1'b1, mk(m_bx, 1 << F_READ) | 24'hF00000, "R1");
        drive(1'b1, mk(m_bx, 0) | 24'hA00000, "R1");
        drive(1'b1, mk(m_bx, 1 << F_READ) | 24'h500000, "R1");

        // R4 event reset, R3 bunch sync via bunch reset and front-end reset
        send((1 << F_EVR) | (1 << F_READ), "R4");
        send(1 << F_READ, "R4");
        drive(1'b1, mk(12'h555, 1 << F_BXR), "R3");
        send(1 << F_READ, "R3");
        drive(1'b1, mk(12'h0AA, (1 << F_FER) | (1 << F_READ)), "R3");
        send(0, "R4");
        send(1 << F_VETO, "R4");
        send(0, "R4");

        // R2 wrap at end of orbit
        while (m_bx != BX_LAST - 3) drive(1'b0, '0, "R2 idle");
        for (int i = 0; i < 7; i++) send(1 << F_READ, "R2");

        // R10 sticky mismatch
        drive(1'b1, mk((m_bx + 5) % (BX_LAST + 1), 1 << F_READ), "R10");
        for (int i = 0; i < 4; i++) send(1 << F_READ, "R10");
        drive(1'b1, mk(12'h123, 1 << F_BXR), "R10");
        send(0, "R10");

        do_reset();
        send(1 << F_READ, "R11");
        send(0, "R11");
        @(negedge clk); #1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule